// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block is the digital sequencer of a dual-slope integrating analog-to-digital converter with a reading range of 0 to 1999. It divides the oscillator by four to form the conversion clock. Each conversion runs through three phases, and each phase has one switch strobe. The first phase is zeroing, where the auto-zero loop settles. The second is a fixed signal integrate. The third is reference de-integrate, during which the block counts conversion clocks until an external comparator reports that the integrator is back at zero.

The de-integrate count is kept in cascaded BCD digits: units, tens, hundreds and a single thousands bit. When de-integrate ends, this count, the input sign and an overrange flag are copied into the reading registers. The zeroing phase absorbs whatever time de-integrate did not use, so one conversion always spans the same number of conversion clocks. The integrator, the analog switches and the reference lie outside the block.

The outputs are latched status levels rather than a data stream. A reading stays valid until the next conversion replaces it, and there is no back-pressure to honour, so the block has no valid/ready handshake.

Top module: `dslope_seq`

## Requirements
- R1: The conversion clock is the oscillator divided by four. The phase strobes change only on conversion-clock edges, and the integrate strobe stays high for exactly 1000 conversion clocks (4000 oscillator cycles).
- R2: In every oscillator cycle exactly one of `sw_zero`, `sw_integ` and `sw_deint` is high. Coming out of reset, `sw_zero` is the one that is high.
- R3: De-integrate ends at the first conversion-clock edge at which `cmp_zero` is high, so it lasts N conversion clocks. If `cmp_zero` is already high at the last integrate edge, de-integrate is skipped and N = 0.
- R4: The reading equals N in BCD. `rd_thou` is the thousands bit, and `rd_hund`, `rd_tens` and `rd_units` each hold a digit from 0 to 9.
- R5: The reading outputs change only one oscillator cycle after de-integrate ends. At all other times they hold their value, including through the next conversion's integrate phase.
- R6: `rd_neg` carries the value of `pol_in` sampled at the last integrate clock, where 1 means negative. It is reported even when the reading is zero.
- R7: If `cmp_zero` is still low after 1999 de-integrate clocks, de-integrate ends there, the reading is 1999 and `rd_ovr` is 1. A trip exactly at the 1999th clock gives 1999 with `rd_ovr` 0.
- R8: The zeroing phase lasts 3000 − N conversion clocks, and 1001 conversion clocks after reset. As a result, integrate strobes start exactly 16000 oscillator cycles apart.
- R9: Reset (asynchronous, active low) clears the reading, the sign and the overrange flag, and selects the zeroing phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_zero | input | 1 | Comparator: integrator has returned to zero |
| pol_in | input | 1 | Input polarity, 1 = negative |
| sw_zero | output | 1 | Zeroing-phase switch strobe |
| sw_integ | output | 1 | Signal-integrate switch strobe |
| sw_deint | output | 1 | Reference de-integrate switch strobe |
| rd_units | output | 4 | Reading, units digit (BCD) |
| rd_tens | output | 4 | Reading, tens digit (BCD) |
| rd_hund | output | 4 | Reading, hundreds digit (BCD) |
| rd_thou | output | 1 | Reading, thousands bit |
| rd_neg | output | 1 | Reading sign, 1 = negative |
| rd_ovr | output | 1 | Overrange flag |

## Verification
The comparator model raises `cmp_zero` so that it is sampled at the conversion-clock edge exactly N clocks after `sw_deint` rises. That is 4N oscillator cycles in. For N = 0 the comparator is held high through the last integrate edge, so de-integrate is skipped. In the first oscillator cycle after `sw_zero` returns, the bench expects the old reading. In the second cycle it expects the new digits, sign and flag. Phase lengths are checked one cycle later, once the strobe has fallen. The spacing between integrate strobes is measured between their rising edges and compared with 16000 cycles, and the zeroing length with 4·(3000 − N).

// File: rtl/dslope_pkg.sv
package dslope_pkg;
  // one-hot phase encoding; bit 0 zeroing, bit 1 integrate, bit 2 de-integrate
  typedef enum logic [2:0] {
    PH_ZERO  = 3'b001,
    PH_INTEG = 3'b010,
    PH_DEINT = 3'b100
  } phase_t;
endpackage

// File: rtl/dsq_clkdiv.sv
module dsq_clkdiv #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                   div_q <= div_q + 1'b1;
  end

  assign tick = (div_q == LAST);

  // R1
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/dsq_bcd_digit.sv
module dsq_bcd_digit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       inc,
  output logic [3:0] digit,
  output logic       wrap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   digit <= '0;
    else if (clr) digit <= '0;
    else if (inc) digit <= (digit == 4'd9) ? 4'd0 : digit + 4'd1;
  end

  assign wrap = inc && (digit == 4'd9);

  // R4
  digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    digit <= 4'd9);
endmodule

// File: rtl/dsq_bcd_chain.sv
module dsq_bcd_chain #(
  parameter int NDIG = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  output logic [NDIG*4-1:0] digits,
  output logic              lead
);
  logic [NDIG:0] carry;
  assign carry[0] = inc;

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    dsq_bcd_digit u_dig (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .inc   (carry[g]),
      .digit (digits[g*4 +: 4]),
      .wrap  (carry[g+1])
    );
  end

  // leading position is a single bit that saturates
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           lead <= 1'b0;
    else if (clr)         lead <= 1'b0;
    else if (carry[NDIG]) lead <= 1'b1;
  end
endmodule

// File: rtl/dsq_phase_ctrl.sv
module dsq_phase_ctrl
  import dslope_pkg::*;
#(
  parameter int CYCLE_CLKS = 4000,
  parameter int INT_CLKS   = 1000,
  parameter int DEINT_MAX  = 1999
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  logic   cmp_zero,
  input  logic   pol_in,
  output phase_t phase,
  output logic   cnt_clr,
  output logic   cnt_inc,
  output logic   done,
  output logic   sign,
  output logic   ovr
);
  localparam int CW = $clog2(CYCLE_CLKS + 1);
  localparam logic [CW-1:0] INT_LAST = CW'(INT_CLKS - 1);
  localparam logic [CW-1:0] ZMAX     = CW'(CYCLE_CLKS - INT_CLKS);
  localparam logic [CW-1:0] DMAX     = CW'(DEINT_MAX);
  localparam logic [CW-1:0] ZMIN     = CW'(CYCLE_CLKS - INT_CLKS - DEINT_MAX);

  logic [CW-1:0] cnt;
  logic [CW-1:0] zero_len;
  logic [CW-1:0] elapsed;

  assign elapsed = cnt + 1'b1;
  assign cnt_clr = tick && (phase == PH_INTEG) && (cnt == INT_LAST);
  assign cnt_inc = tick && (phase == PH_DEINT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_ZERO;
      cnt      <= '0;
      zero_len <= ZMIN;
      done     <= 1'b0;
      sign     <= 1'b0;
      ovr      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        unique case (phase)
          PH_ZERO: begin
            if (elapsed == zero_len) begin
              phase <= PH_INTEG;
              cnt   <= '0;
            end else begin
              cnt <= elapsed;
            end
          end
          PH_INTEG: begin
            if (cnt == INT_LAST) begin
              sign <= pol_in;
              cnt  <= '0;
              if (cmp_zero) begin
                phase    <= PH_ZERO;
                zero_len <= ZMAX;
                ovr      <= 1'b0;
                done     <= 1'b1;
              end else begin
                phase <= PH_DEINT;
              end
            end else begin
              cnt <= elapsed;
            end
          end
          PH_DEINT: begin
            if (cmp_zero || (elapsed == DMAX)) begin
              phase    <= PH_ZERO;
              zero_len <= ZMAX - elapsed;
              ovr      <= !cmp_zero;
              done     <= 1'b1;
              cnt      <= '0;
            end else begin
              cnt <= elapsed;
            end
          end
          default: phase <= PH_ZERO;
        endcase
      end
    end
  end

  // R1
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase));
  // R2
  onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phase) == 1);
  // R3
  trip_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && phase == PH_DEINT && cmp_zero) |=> (phase == PH_ZERO));
  // R8
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_len >= ZMIN) && (zero_len <= ZMAX));
endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
  import dslope_pkg::*;
#(
  parameter int OSC_DIV    = 4,
  parameter int CYCLE_CLKS = 4000,
  parameter int INT_CLKS   = 1000,
  parameter int DEINT_MAX  = 1999
) (
  input  logic       osc_clk,
  input  logic       rst_n,
  input  logic       cmp_zero,
  input  logic       pol_in,
  output logic       sw_zero,
  output logic       sw_integ,
  output logic       sw_deint,
  output logic [3:0] rd_units,
  output logic [3:0] rd_tens,
  output logic [3:0] rd_hund,
  output logic       rd_thou,
  output logic       rd_neg,
  output logic       rd_ovr
);
  localparam int NDIG = 3;
  localparam logic [3:0] MAX_U = 4'(DEINT_MAX % 10);
  localparam logic [3:0] MAX_T = 4'((DEINT_MAX / 10) % 10);
  localparam logic [3:0] MAX_H = 4'((DEINT_MAX / 100) % 10);
  localparam logic       MAX_K = (DEINT_MAX >= 1000);

  logic              tick;
  phase_t            phase;
  logic              cnt_clr, cnt_inc, done, sign, ovr;
  logic [NDIG*4-1:0] digits;
  logic              lead;

  dsq_clkdiv #(.DIV(OSC_DIV)) u_div (
    .clk   (osc_clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  dsq_phase_ctrl #(
    .CYCLE_CLKS (CYCLE_CLKS),
    .INT_CLKS   (INT_CLKS),
    .DEINT_MAX  (DEINT_MAX)
  ) u_ctrl (
    .clk      (osc_clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .cmp_zero (cmp_zero),
    .pol_in   (pol_in),
    .phase    (phase),
    .cnt_clr  (cnt_clr),
    .cnt_inc  (cnt_inc),
    .done     (done),
    .sign     (sign),
    .ovr      (ovr)
  );

  dsq_bcd_chain #(.NDIG(NDIG)) u_cnt (
    .clk    (osc_clk),
    .rst_n  (rst_n),
    .clr    (cnt_clr),
    .inc    (cnt_inc),
    .digits (digits),
    .lead   (lead)
  );

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_units <= '0;
      rd_tens  <= '0;
      rd_hund  <= '0;
      rd_thou  <= 1'b0;
      rd_neg   <= 1'b0;
      rd_ovr   <= 1'b0;
    end else if (done) begin
      rd_units <= digits[3:0];
      rd_tens  <= digits[7:4];
      rd_hund  <= digits[11:8];
      rd_thou  <= lead;
      rd_neg   <= sign;
      rd_ovr   <= ovr;
    end
  end

  assign sw_zero  = phase[0];
  assign sw_integ = phase[1];
  assign sw_deint = phase[2];

  // R5
  rd_hold_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    !done |=> $stable({rd_thou, rd_hund, rd_tens, rd_units, rd_neg, rd_ovr}));
  // R7
  ovr_value_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    rd_ovr |-> (rd_thou == MAX_K && rd_hund == MAX_H && rd_tens == MAX_T && rd_units == MAX_U));
endmodule

// File: tb/sim_dslope_seq.sv
module sim_dslope_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_zero = 1'b0;
  logic       pol_in = 1'b0;
  logic       sw_zero, sw_integ, sw_deint;
  logic [3:0] rd_units, rd_tens, rd_hund;
  logic       rd_thou, rd_neg, rd_ovr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int cur_n = 5000;
  int bad_oh = 0;
  int integ_run = 0, deint_run = 0, zero_run = 0;
  int integ_len = 0, deint_len = 0, zero_len = 0;

  always #4 clk = ~clk;  // 125 MHz

  dslope_seq u0 (
    .osc_clk (clk), .rst_n (rst_n), .cmp_zero (cmp_zero), .pol_in (pol_in),
    .sw_zero (sw_zero), .sw_integ (sw_integ), .sw_deint (sw_deint),
    .rd_units (rd_units), .rd_tens (rd_tens), .rd_hund (rd_hund),
    .rd_thou (rd_thou), .rd_neg (rd_neg), .rd_ovr (rd_ovr)
  );

  function automatic int rd_value();
    return rd_thou * 1000 + rd_hund * 100 + rd_tens * 10 + rd_units;
  endfunction

  function automatic int expect_reading(int n);
    return (n > 1999) ? 1999 : n;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 180000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // strobe run lengths and comparator model, all at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if ($countones({sw_zero, sw_integ, sw_deint}) != 1) bad_oh++;
      if (sw_integ) begin integ_run++; deint_len = 0; end
      else if (integ_run != 0) begin integ_len = integ_run; integ_run = 0; end
      if (sw_deint) deint_run++;
      else if (deint_run != 0) begin deint_len = deint_run; deint_run = 0; end
      if (sw_zero) zero_run++;
      else if (zero_run != 0) begin zero_len = zero_run; zero_run = 0; end
      cmp_zero = (cur_n == 0) ? 1'b1 : (sw_deint && (deint_run >= 4 * cur_n));
    end
  end

  initial begin
    int ns[8];
    int prev_exp = 0;
    int prev_neg = 0;
    int t_prev = 0;
    void'($urandom(32'd2024));
    ns[0] = 0; ns[1] = 2500; ns[2] = 1999; ns[3] = 1;
    for (int i = 4; i < 8; i++) ns[i] = $urandom_range(1998, 2);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state, R2 zeroing after reset
    check(sw_zero && !sw_integ && !sw_deint, "R2 reset phase", {sw_zero, sw_integ, sw_deint}, 3'b100);
    check(rd_value() == 0 && !rd_neg && !rd_ovr, "R9 reset reading", rd_value(), 0);

    for (int i = 0; i < 8; i++) begin
      int t_now;
      int exp_r;
      bit pol;
      while (!sw_integ) @(negedge clk);
      t_now = cyc;
      @(negedge clk);
      if (i > 0) begin
        check(zero_len == 4 * (3000 - prev_exp), "R8 zeroing length", zero_len, 4 * (3000 - prev_exp));
        check(t_now - t_prev == 16000, "R8 cycle spacing", t_now - t_prev, 16000);
        check(rd_value() == prev_exp && rd_neg == prev_neg, "R5 hold during integrate", rd_value(), prev_exp);
      end else begin
        check(zero_len == 4 * 1001, "R8 first zeroing", zero_len, 4 * 1001);
      end
      t_prev = t_now;
      pol = $urandom_range(1, 0);
      if (i == 0) pol = 1'b1;
      pol_in = pol;
      cur_n = ns[i];
      exp_r = expect_reading(ns[i]);

      while (sw_integ) @(negedge clk);
      while (!sw_zero) @(negedge clk);
      check(rd_value() == prev_exp, "R5 not yet latched", rd_value(), prev_exp);
      @(negedge clk);
      cur_n = 5000;
      check(rd_value() == exp_r, "R4 reading", rd_value(), exp_r);
      check(rd_units <= 9 && rd_tens <= 9 && rd_hund <= 9, "R4 digit range", rd_units, 9);
      check(rd_neg == pol, "R6 sign", rd_neg, pol);
      check(rd_ovr == (ns[i] > 1999), "R7 overrange flag", rd_ovr, ns[i] > 1999);
      @(negedge clk);
      check(integ_len == 4000, "R1 integrate length", integ_len, 4000);
      check(deint_len == 4 * exp_r, "R3 de-integrate length", deint_len, 4 * exp_r);
      prev_exp = exp_r;
      prev_neg = pol;
    end

    check(bad_oh == 0, "R2 one-hot strobes", bad_oh, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule